// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter with Holding Register

This block serialises nine-bit characters onto a single line. Every character goes out as an eleven-bit frame. The frame is a low start bit, then eight data bits with the least significant bit first, then a ninth bit chosen by the writer, then a high stop bit. Each bit lasts a fixed number of baud ticks, and an external divider supplies those ticks. The line rests high whenever no frame is in flight.

A holding register can sit in front of the shift register, under the control of a mode input. With the holding register enabled, software may write the next character while the current one is still shifting. When the current stop bit ends, the shifter takes the held character in the same clock, so consecutive frames are separated by exactly one stop bit. With the holding register disabled, the block behaves like a plain single-buffer transmitter and only accepts a write while the line is idle. In either mode, a write that finds no free storage is dropped and raises a sticky overrun flag. A one-clock completion pulse marks the end of every frame.

Top module: `uart9_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `tx_done` is 0 and `overrun` is 0.
- R2: A frame is 11 bits on `txd`: bit 0 is 0 (start), bits 1..8 are `wr_data[0]`..`wr_data[7]`, bit 9 is `wr_bit9`, and bit 10 is 1 (stop). Outside a frame `txd` is 1.
- R3: Each frame bit lasts exactly TICKS_PER_BIT (default 16) clock cycles in which `baud_tick` is 1. Cycles with `baud_tick` at 0 never advance the line.
- R4: With `dbuf_en`=1, a write is taken into the holding register whenever it is empty, including while a frame is shifting. `hold_empty` reads 0 from the cycle after that write until the shifter takes the character.
- R5: With `dbuf_en`=1 and a character held, the shifter loads it on the clock edge that ends the stop bit. The new start bit is on `txd` in the very next cycle, so exactly one stop bit separates the two frames.
- R6: The start bit appears one cycle after a write captured while the line is idle when `dbuf_en`=0, and two cycles after it when `dbuf_en`=1, because the character passes through the holding register.
- R7: With `dbuf_en`=0, a write while a frame is shifting is ignored: it is never sent and it sets `overrun`. `hold_empty` is 0 while a frame is shifting.
- R8: With `dbuf_en`=1, a write while the holding register is full and the shifter cannot take the held character that cycle is ignored. The held character is kept unchanged and `overrun` is set on the next cycle.
- R9: `overrun` stays 1 until reset.
- R10: `tx_done` is a one-cycle pulse in the cycle after the clock edge that ends a stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle tick; TICKS_PER_BIT ticks form one bit time |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Data byte of the character |
| wr_bit9 | input | 1 | Ninth bit of the character |
| dbuf_en | input | 1 | 1 enables the holding register, 0 selects single-buffer behaviour |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | A write would currently be accepted (see R4, R7) |
| tx_done | output | 1 | One-cycle pulse at the end of each frame |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
Each result has a fixed latency, counted from the rising edge that captures a write:
- The start bit follows one cycle later in single-buffer mode and two cycles later through the holding register.
- `hold_empty` and `overrun` change one cycle later.
- A bit boundary falls on the edge carrying the last baud tick of the bit. On the edge that ends a stop bit, `tx_done` and any chained start bit appear together.

The bench keeps a behavioural model built from queues and integers. The model steps on each rising edge using the inputs held since the previous edge. All four outputs are compared against it on the falling edge that follows, so every comparison lands after exactly one register stage. Directed checks wait a known number of edges before sampling the latency and gap cases.

// File: rtl/uart9_pkg.sv
// Shared constants and the character type of the nine-bit transmitter.
// Assumes an eleven-bit frame: start, DATA_W data bits, ninth bit, stop.
package uart9_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 3;

    // Character as written: {ninth bit, data byte}
    typedef logic [DATA_W:0] tx_word_t;
endpackage

// File: rtl/tx_bit_timer.sv
// Counts baud ticks within a bit and bits within a frame.
// Assumes TICKS_PER_BIT >= 2 and that 'start' restarts the count at bit 0.
module tx_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    parameter int FRAME_BITS    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    input  logic baud_tick,
    output logic bit_end,
    output logic frame_end
);
    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam int IW = $clog2(FRAME_BITS);

    logic [TW-1:0] tick_cnt;
    logic [IW-1:0] bit_idx;

    // Decode the last tick of a bit and the last bit of a frame
    always_comb begin
        bit_end   = run && baud_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
        frame_end = bit_end && (bit_idx == IW'(FRAME_BITS - 1));
    end

    // Advance the tick counter and the bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (start) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (bit_end) begin
            tick_cnt <= '0;
            bit_idx  <= frame_end ? '0 : bit_idx + IW'(1);
        end else if (run && baud_tick) begin
            tick_cnt <= tick_cnt + TW'(1);
        end
    end

    // R3
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && !baud_tick) |=> ($stable(tick_cnt) && $stable(bit_idx)));
endmodule

// File: rtl/tx_frame_shifter.sv
// Holds the frame being sent and shifts it out least significant bit first.
// Assumes 'load' is only raised when the shifter is idle or at frame end.
module tx_frame_shifter
    import uart9_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  tx_word_t load_word,
    input  logic     bit_end,
    input  logic     frame_end,
    output logic     busy,
    output logic     txd
);
    logic [FRAME_BITS-1:0] shreg;

    // Load a new frame, drop to idle after the stop bit, or shift one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
        end else if (load) begin
            busy  <= 1'b1;
            shreg <= {1'b1, load_word, 1'b0};
        end else if (frame_end) begin
            busy  <= 1'b0;
            shreg <= '1;
        end else if (bit_end) begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        end
    end

    // Drive the line: current bit while busy, high when idle
    always_comb txd = busy ? shreg[0] : 1'b1;

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !txd));
    // R2
    stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> txd);
    // R5
    idle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !load) |=> (!busy && txd));
endmodule

// File: rtl/tx_hold_buf.sv
// Holding register and write acceptance for the transmitter.
// Chooses whether the shifter loads from the holding register or directly
// from the write port, and flags writes that find no free storage.
// Assumes 'busy' and 'frame_end' come from the shifter and bit timer.
module tx_hold_buf
    import uart9_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  tx_word_t wr_word,
    input  logic     dbuf_en,
    input  logic     busy,
    input  logic     frame_end,
    output logic     hold_full,
    output logic     load,
    output tx_word_t load_word,
    output logic     overrun
);
    tx_word_t hold_word;
    logic     pull;
    logic     direct;
    logic     take;

    // Decide transfers: held word to shifter, direct load, or capture into hold
    always_comb begin
        pull      = hold_full && (!busy || frame_end);
        direct    = wr_en && !dbuf_en && !busy && !hold_full;
        take      = wr_en && dbuf_en && (!hold_full || pull);
        load      = pull || direct;
        load_word = pull ? hold_word : wr_word;
    end

    // Update the holding register occupancy and contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_word <= '0;
        end else if (take) begin
            hold_full <= 1'b1;
            hold_word <= wr_word;
        end else if (pull) begin
            hold_full <= 1'b0;
        end
    end

    // Record any write that was neither held nor loaded
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (wr_en && !take && !direct)
            overrun <= 1'b1;
    end

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_full && !pull) |=> (hold_full && $stable(hold_word) && overrun));
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R7
    single_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dbuf_en && busy) |=> overrun);
endmodule

// File: rtl/uart9_tx.sv
// Nine-bit asynchronous transmitter with an optional holding register.
// Assumes baud_tick is a single-cycle pulse from an external divider and
// that dbuf_en is held steady while characters are in flight.
module uart9_tx #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        baud_tick,
    input  logic                        wr_en,
    input  logic [uart9_pkg::DATA_W-1:0] wr_data,
    input  logic                        wr_bit9,
    input  logic                        dbuf_en,
    output logic                        txd,
    output logic                        hold_empty,
    output logic                        tx_done,
    output logic                        overrun
);
    import uart9_pkg::*;

    logic     busy;
    logic     bit_end;
    logic     frame_end;
    logic     hold_full;
    logic     load;
    tx_word_t load_word;
    tx_word_t wr_word;

    // Pack the written character
    always_comb wr_word = {wr_bit9, wr_data};

    tx_hold_buf u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .dbuf_en   (dbuf_en),
        .busy      (busy),
        .frame_end (frame_end),
        .hold_full (hold_full),
        .load      (load),
        .load_word (load_word),
        .overrun   (overrun)
    );

    tx_bit_timer #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .FRAME_BITS    (FRAME_BITS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .start     (load),
        .baud_tick (baud_tick),
        .bit_end   (bit_end),
        .frame_end (frame_end)
    );

    tx_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .bit_end   (bit_end),
        .frame_end (frame_end),
        .busy      (busy),
        .txd       (txd)
    );

    // Writable-state flag: holding register in buffered mode, shifter otherwise
    always_comb hold_empty = dbuf_en ? !hold_full : (!hold_full && !busy);

    // Register the end-of-frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n) tx_done <= 1'b0;
        else        tx_done <= frame_end;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    // R4
    hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dbuf_en && hold_empty) |=> !hold_empty);
endmodule

// File: tb/uart9_tx_tb_top.sv
// Self-checking bench: behavioural model stepped on rising edges, compared
// on falling edges, plus directed latency and corner-case checks.
module uart9_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit9 = 1'b0;
    logic       dbuf_en = 1'b0;
    logic       txd, hold_empty, tx_done, overrun;

    int vecs = 0;
    int fails = 0;
    int cyc = 0;
    int tick_div = 3;
    int tick_ph = 0;
    bit tick_off = 1'b0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    uart9_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_bit9(wr_bit9), .dbuf_en(dbuf_en),
        .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    // Baud tick source
    always @(posedge clk) begin
        #1;
        if (tick_ph >= tick_div - 1) begin
            tick_ph = 0;
            baud_tick = !tick_off;
        end else begin
            tick_ph++;
            baud_tick = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // Behavioural reference model
    bit         m_busy = 0;
    int         m_bit = 0;
    int         m_tick = 0;
    logic [8:0] m_cur = '0;
    logic [8:0] hq[$];
    bit         m_ovr = 0;
    bit         m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_bit = 0; m_tick = 0; hq.delete(); m_ovr = 0; m_done = 0;
        end else begin
            bit bend, fend, pull, direct, acc;
            bend   = m_busy && baud_tick && (m_tick == 15);
            fend   = bend && (m_bit == 10);
            pull   = (hq.size() > 0) && (!m_busy || fend);
            direct = wr_en && !dbuf_en && !m_busy && (hq.size() == 0);
            acc    = wr_en && dbuf_en && ((hq.size() == 0) || pull);
            m_done = fend;
            if (pull) begin
                m_cur = hq.pop_front(); m_busy = 1; m_bit = 0; m_tick = 0;
            end else if (direct) begin
                m_cur = {wr_bit9, wr_data}; m_busy = 1; m_bit = 0; m_tick = 0;
            end else if (fend) begin
                m_busy = 0; m_bit = 0; m_tick = 0;
            end else if (bend) begin
                m_bit++; m_tick = 0;
            end else if (m_busy && baud_tick) begin
                m_tick++;
            end
            if (acc) hq.push_back({wr_bit9, wr_data});
            if (wr_en && !acc && !direct) m_ovr = 1;
        end
    end

    function automatic bit exp_txd();
        if (!m_busy)      return 1'b1;
        if (m_bit == 0)   return 1'b0;
        if (m_bit <= 8)   return m_cur[m_bit-1];
        if (m_bit == 9)   return m_cur[8];
        return 1'b1;
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit eh;
            eh = dbuf_en ? (hq.size() == 0) : ((hq.size() == 0) && !m_busy);
            chk(txd == exp_txd(), "R2 R3 txd vs model", txd, exp_txd());
            chk(hold_empty == eh, "R4 hold_empty vs model", hold_empty, eh);
            chk(tx_done == m_done, "R10 tx_done vs model", tx_done, m_done);
            chk(overrun == m_ovr, "R8 overrun vs model", overrun, m_ovr);
            if (tx_done) done_cnt++;
        end
    end

    task automatic send(input logic [8:0] w);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = w[7:0]; wr_bit9 = w[8];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
        chk(tx_done == 1'b0, "R1 tx_done", tx_done, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);

        // Buffered mode, tick every third cycle
        dbuf_en = 1'b1;
        send(9'h1A5);
        @(negedge clk);
        chk(txd == 1'b1, "R6 buffered, one cycle after write", txd, 1);
        chk(hold_empty == 1'b0, "R4 hold taken", hold_empty, 0);
        @(negedge clk);
        chk(txd == 1'b0, "R6 buffered start bit", txd, 0);
        repeat (30) @(posedge clk);
        #1;
        send(9'h03C);
        @(negedge clk);
        chk(hold_empty == 1'b0, "R4 write while shifting", hold_empty, 0);
        chk(overrun == 1'b0, "R4 no overrun", overrun, 0);
        send(9'h0FF);
        @(negedge clk);
        chk(overrun == 1'b1, "R8 write into full hold", overrun, 1);
        begin
            logic t;
            tick_off = 1'b1;
            repeat (3) @(negedge clk);
            t = txd;
            repeat (40) @(negedge clk);
            chk(txd == t, "R3 no ticks, line frozen", txd, t);
            tick_off = 1'b0;
        end
        do @(negedge clk); while (!tx_done);
        chk(txd == 1'b0, "R5 chained start bit", txd, 0);
        chk(hold_empty == 1'b1, "R5 hold drained", hold_empty, 1);
        @(negedge clk);
        chk(tx_done == 1'b0, "R10 single pulse", tx_done, 0);
        do @(negedge clk); while (!tx_done);
        @(negedge clk);
        chk(txd == 1'b1, "R8 dropped byte not sent", txd, 1);
        chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

        // Single-buffer mode, tick every second cycle
        do_reset();
        @(negedge clk);
        chk(overrun == 1'b0, "R9 cleared by reset", overrun, 0);
        dbuf_en = 1'b0;
        tick_div = 2;
        send(9'h155);
        @(negedge clk);
        chk(txd == 1'b0, "R6 single start bit", txd, 0);
        chk(hold_empty == 1'b0, "R7 busy not writable", hold_empty, 0);
        repeat (20) @(posedge clk);
        #1;
        send(9'h0AA);
        @(negedge clk);
        chk(overrun == 1'b1, "R7 write while busy", overrun, 1);
        do @(negedge clk); while (!tx_done);
        @(negedge clk);
        chk(txd == 1'b1, "R7 ignored byte not sent", txd, 1);

        // Buffered stream, tick every cycle
        do_reset();
        dbuf_en = 1'b1;
        tick_div = 1;
        done_cnt = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            while (!hold_empty) @(negedge clk);
            send(9'((i * 83 + 17) % 512));
        end
        repeat (6 * 176 + 40) @(posedge clk);
        @(negedge clk);
        chk(done_cnt == 5, "R5 back-to-back frame count", done_cnt, 5);
        chk(overrun == 1'b0, "R5 stream without overrun", overrun, 0);
        finish_run();
    end
endmodule